// File: doc/BRIEF.md
# UART Register and Interrupt Controller

This block is the software-visible face of a serial port. It decodes word accesses on a 32-bit bus with a 4 KB address window. It stores the configuration registers that the serial engine consumes: the integer and fractional baud divisors, the line format, the control word, the FIFO trigger levels, the infrared low-power divisor and the DMA enables. It also keeps the raw interrupt status and the interrupt mask.

The character engine and the FIFO storage sit outside this block. They report their events as single-cycle pulses on a set vector, supply the current flag word, and present the head of the receive queue. The block answers with a pop pulse when software reads the data register, and with a transmit strobe carrying the written byte.

Six registered interrupt lines leave the block. One is the OR of every masked source. The other five cover the receive, transmit, receive-timeout, modem-status and error groups. The top eight words of the window return a fixed identification byte sequence.

Top module: `uart_rif_top`

## Requirements
- R1: After a synchronous reset, the mask, raw status, DMA enable, infrared divisor, both baud divisors, line format and control registers read zero, the FIFO-level register reads 0x12, and all six interrupt lines are low.
- R2: Reading the masked-status register (offset 0x040) returns the raw status (offset 0x03C) ANDed with the mask register (offset 0x038).
- R3: Writing the clear register (offset 0x044) clears every raw-status bit whose written bit is one and leaves the rest; reading the clear register always returns zero.
- R4: Writes to the flag (0x018), raw-status and masked-status offsets change no stored state; the flag offset always reads back the `line_flags` input.
- R5: The interrupt lines are registered and follow the masked status one clock after it changes. Line 0 is the OR of all masked bits. Lines 1 to 5 are the receive bit 4, the transmit bit 5, the receive-timeout bit 6, the modem group bits 0 to 3 and the error group bits 7 to 10 respectively.
- R6: Every write to the data register (offset 0x000) sets raw-status bit 5 and raises `tx_strobe` for one cycle with the low byte of the write on `tx_byte`.
- R7: A pulse on bit n of `evt_set` sets raw-status bit n. When a clear of the same bit lands in the same cycle, the set wins.
- R8: Reads at offsets 0xFE0, 0xFE4, …, 0xFFC return 0x11, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in that order. Any other unmapped offset reads zero.
- R9: The integer divisor (offset 0x024) keeps the low 16 bits of a write and the fractional divisor (offset 0x028) keeps the low 6 bits.
- R10: A read of the data register returns `rx_word` and raises `rx_pop` for one cycle.
- R11: Read data is registered. It appears on `bus_rdata` after the clock edge that samples `bus_rd` and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Word write strobe |
| bus_rd | input | 1 | Word read strobe |
| bus_addr | input | 12 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| rx_word | input | 12 | Head of the receive queue (data plus error bits) |
| line_flags | input | 9 | Flag word from the serial engine |
| evt_set | input | 11 | Raw-status set pulses, one bit per source |
| rx_pop | output | 1 | One-cycle pulse after a data-register read |
| tx_strobe | output | 1 | One-cycle pulse after a data-register write |
| tx_byte | output | 8 | Byte written with the last data-register write |
| irq_out | output | 6 | Combined line and five group lines |
| baud_int | output | 16 | Integer baud divisor |
| baud_frac | output | 6 | Fractional baud divisor |
| line_cfg | output | 8 | Line format register |
| ctl_cfg | output | 16 | Control register |
| fifo_lvl | output | 6 | FIFO trigger level register |
| irda_div | output | 8 | Infrared low-power divisor |
| dma_cfg | output | 3 | DMA enable register |

## Verification
Raw-status bits are set three ways: by data-register writes, by single event pulses, and by an event pulse that coincides with a clear of the same bit. Comparing the raw and masked reads across full, partial and empty masks separates masking faults from status-storage faults. One event from each group is raised while its group line is observed one and two cycles later. This catches a wrong group mapping and a wrong pipeline depth. Oversized divisor writes, writes to the read-only offsets, and reads across the identification words and an unmapped hole confirm truncation, ignored writes and decode boundaries.

// File: rtl/uart_rif_pkg.sv
package uart_rif_pkg;
  localparam int NSRC  = 11;
  localparam int NIRQ  = 6;

  // word-aligned byte offsets
  localparam logic [11:0] A_DATA  = 12'h000;
  localparam logic [11:0] A_FLAG  = 12'h018;
  localparam logic [11:0] A_IRDA  = 12'h020;
  localparam logic [11:0] A_BINT  = 12'h024;
  localparam logic [11:0] A_BFRC  = 12'h028;
  localparam logic [11:0] A_LINE  = 12'h02C;
  localparam logic [11:0] A_CTRL  = 12'h030;
  localparam logic [11:0] A_FLVL  = 12'h034;
  localparam logic [11:0] A_MASK  = 12'h038;
  localparam logic [11:0] A_RAW   = 12'h03C;
  localparam logic [11:0] A_MSKD  = 12'h040;
  localparam logic [11:0] A_CLR   = 12'h044;
  localparam logic [11:0] A_DMA   = 12'h048;
  localparam logic [11:0] A_IDBASE = 12'hFE0;

  localparam int B_TX = 5;

  localparam logic [NSRC-1:0] G_ALL   = 11'h7FF;
  localparam logic [NSRC-1:0] G_RX    = 11'h010;
  localparam logic [NSRC-1:0] G_TX    = 11'h020;
  localparam logic [NSRC-1:0] G_RT    = 11'h040;
  localparam logic [NSRC-1:0] G_MODEM = 11'h00F;
  localparam logic [NSRC-1:0] G_ERR   = 11'h780;

  function automatic logic [NSRC-1:0] line_group(input int idx);
    case (idx)
      0: line_group = G_ALL;
      1: line_group = G_RX;
      2: line_group = G_TX;
      3: line_group = G_RT;
      4: line_group = G_MODEM;
      default: line_group = G_ERR;
    endcase
  endfunction

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0: id_byte = 8'h11;
      3'd1: id_byte = 8'h10;
      3'd2: id_byte = 8'h14;
      3'd3: id_byte = 8'h00;
      3'd4: id_byte = 8'h0D;
      3'd5: id_byte = 8'hF0;
      3'd6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/uart_cfg_regs.sv
module uart_cfg_regs #(
  parameter int IBAUD_W = 16,
  parameter int FBAUD_W = 6,
  parameter int LINE_W  = 8,
  parameter int CTRL_W  = 16,
  parameter int FLVL_W  = 6,
  parameter int IRDA_W  = 8,
  parameter int DMA_W   = 3,
  parameter logic [FLVL_W-1:0] FLVL_RST = 6'h12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [11:0]        addr,
  input  logic [31:0]        wdata,
  output logic [IBAUD_W-1:0] baud_int,
  output logic [FBAUD_W-1:0] baud_frac,
  output logic [LINE_W-1:0]  line_cfg,
  output logic [CTRL_W-1:0]  ctl_cfg,
  output logic [FLVL_W-1:0]  fifo_lvl,
  output logic [IRDA_W-1:0]  irda_div,
  output logic [DMA_W-1:0]   dma_cfg
);
  import uart_rif_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      baud_int  <= '0;
      baud_frac <= '0;
      line_cfg  <= '0;
      ctl_cfg   <= '0;
      fifo_lvl  <= FLVL_RST;
      irda_div  <= '0;
      dma_cfg   <= '0;
    end else if (we) begin
      case (addr)
        A_BINT: baud_int  <= wdata[IBAUD_W-1:0];
        A_BFRC: baud_frac <= wdata[FBAUD_W-1:0];
        A_LINE: line_cfg  <= wdata[LINE_W-1:0];
        A_CTRL: ctl_cfg   <= wdata[CTRL_W-1:0];
        A_FLVL: fifo_lvl  <= wdata[FLVL_W-1:0];
        A_IRDA: irda_div  <= wdata[IRDA_W-1:0];
        A_DMA:  dma_cfg   <= wdata[DMA_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/uart_irq_core.sv
module uart_irq_core #(
  parameter int NSRC = 11,
  parameter int NIRQ = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            mask_we,
  input  logic            clr_we,
  input  logic            tx_we,
  input  logic [NSRC-1:0] wval,
  input  logic [NSRC-1:0] evt_set,
  output logic [NSRC-1:0] raw_q,
  output logic [NSRC-1:0] mask_q,
  output logic [NIRQ-1:0] irq_q
);
  import uart_rif_pkg::*;

  logic [NSRC-1:0] set_vec;
  logic [NSRC-1:0] clr_vec;
  logic [NSRC-1:0] masked;

  always_comb begin
    set_vec = evt_set;
    if (tx_we) set_vec[B_TX] = 1'b1;
    clr_vec = clr_we ? wval : '0;
    masked  = raw_q & mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      raw_q <= (raw_q & ~clr_vec) | set_vec;
      if (mask_we) mask_q <= wval;
    end
  end

  for (genvar g = 0; g < NIRQ; g++) begin : g_line
    localparam logic [NSRC-1:0] GRP = line_group(g);
    always_ff @(posedge clk) begin
      if (rst) irq_q[g] <= 1'b0;
      else     irq_q[g] <= |(masked & GRP);
    end
  end
endmodule

// File: rtl/uart_rif_top.sv
module uart_rif_top #(
  parameter int ADDR_W  = 12,
  parameter int IBAUD_W = 16,
  parameter int FBAUD_W = 6,
  parameter int RXW_W   = 12,
  parameter int FLAG_W  = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [RXW_W-1:0]   rx_word,
  input  logic [FLAG_W-1:0]  line_flags,
  input  logic [10:0]        evt_set,
  output logic               rx_pop,
  output logic               tx_strobe,
  output logic [7:0]         tx_byte,
  output logic [5:0]         irq_out,
  output logic [IBAUD_W-1:0] baud_int,
  output logic [FBAUD_W-1:0] baud_frac,
  output logic [7:0]         line_cfg,
  output logic [15:0]        ctl_cfg,
  output logic [5:0]         fifo_lvl,
  output logic [7:0]         irda_div,
  output logic [2:0]         dma_cfg
);
  import uart_rif_pkg::*;

  logic [11:0]     waddr;
  logic [NSRC-1:0] raw_q;
  logic [NSRC-1:0] mask_q;
  logic [31:0]     rd_mux;

  assign waddr = {bus_addr[11:2], 2'b00};

  uart_cfg_regs #(
    .IBAUD_W(IBAUD_W), .FBAUD_W(FBAUD_W)
  ) u_cfg (
    .clk(clk), .rst(rst), .we(bus_wr), .addr(waddr), .wdata(bus_wdata),
    .baud_int(baud_int), .baud_frac(baud_frac), .line_cfg(line_cfg),
    .ctl_cfg(ctl_cfg), .fifo_lvl(fifo_lvl), .irda_div(irda_div),
    .dma_cfg(dma_cfg)
  );

  uart_irq_core #(.NSRC(NSRC), .NIRQ(NIRQ)) u_irq (
    .clk(clk), .rst(rst),
    .mask_we(bus_wr && waddr == A_MASK),
    .clr_we(bus_wr && waddr == A_CLR),
    .tx_we(bus_wr && waddr == A_DATA),
    .wval(bus_wdata[NSRC-1:0]),
    .evt_set(evt_set),
    .raw_q(raw_q), .mask_q(mask_q), .irq_q(irq_out)
  );

  always_comb begin
    rd_mux = '0;
    if (waddr >= A_IDBASE) begin
      rd_mux[7:0] = id_byte(waddr[4:2]);
    end else begin
      case (waddr)
        A_DATA: rd_mux[RXW_W-1:0]   = rx_word;
        A_FLAG: rd_mux[FLAG_W-1:0]  = line_flags;
        A_IRDA: rd_mux[7:0]         = irda_div;
        A_BINT: rd_mux[IBAUD_W-1:0] = baud_int;
        A_BFRC: rd_mux[FBAUD_W-1:0] = baud_frac;
        A_LINE: rd_mux[7:0]         = line_cfg;
        A_CTRL: rd_mux[15:0]        = ctl_cfg;
        A_FLVL: rd_mux[5:0]         = fifo_lvl;
        A_MASK: rd_mux[NSRC-1:0]    = mask_q;
        A_RAW:  rd_mux[NSRC-1:0]    = raw_q;
        A_MSKD: rd_mux[NSRC-1:0]    = raw_q & mask_q;
        A_DMA:  rd_mux[2:0]         = dma_cfg;
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      rx_pop    <= 1'b0;
      tx_strobe <= 1'b0;
      tx_byte   <= '0;
    end else begin
      if (bus_rd) bus_rdata <= rd_mux;
      rx_pop    <= bus_rd && waddr == A_DATA;
      tx_strobe <= bus_wr && waddr == A_DATA;
      if (bus_wr && waddr == A_DATA) tx_byte <= bus_wdata[7:0];
    end
  end
endmodule

// File: rtl/uart_rif_chk.sv
module uart_rif_chk (
  input logic        clk,
  input logic        rst,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic [11:0] bus_addr,
  input logic [31:0] bus_rdata,
  input logic [10:0] raw_q,
  input logic [10:0] mask_q,
  input logic [10:0] evt_set,
  input logic [5:0]  irq_out,
  input logic        tx_strobe
);
  logic armed;
  always_ff @(posedge clk) armed <= rst ? 1'b1 : armed;

  // R2
  masked_read_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    (bus_rd && bus_addr == 12'h040) |=> bus_rdata == {21'd0, $past(raw_q & mask_q)});

  // R3
  clear_reads_zero_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    (bus_rd && bus_addr == 12'h044) |=> bus_rdata == 32'd0);

  // R5
  combined_line_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    1'b1 |=> irq_out[0] == $past(|(raw_q & mask_q)));

  // R5
  error_line_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    1'b1 |=> irq_out[5] == $past(|(raw_q & mask_q & 11'h780)));

  // R6
  data_write_tx_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    (bus_wr && bus_addr == 12'h000) |=> (raw_q[5] && tx_strobe));

  // R7
  event_set_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    evt_set[9] |=> raw_q[9]);

  // R8
  id_first_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    (bus_rd && bus_addr == 12'hFE0) |=> bus_rdata == 32'h11);
endmodule

bind uart_rif_top uart_rif_chk u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .raw_q(raw_q), .mask_q(mask_q), .evt_set(evt_set),
  .irq_out(irq_out), .tx_strobe(tx_strobe)
);

// File: tb/uart_rif_top_test.sv
module uart_rif_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [11:0] rx_word = 12'h5A3;
  logic [8:0]  line_flags = 9'h0A5;
  logic [10:0] evt_set = '0;
  logic        rx_pop, tx_strobe;
  logic [7:0]  tx_byte;
  logic [5:0]  irq_out;
  logic [15:0] baud_int;
  logic [5:0]  baud_frac, fifo_lvl;
  logic [7:0]  line_cfg, irda_div;
  logic [15:0] ctl_cfg;
  logic [2:0]  dma_cfg;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  uart_rif_top uut (.*);

  // {rd, addr, data-or-expected, requirement number}
  localparam int NV = 28;
  localparam logic [48:0] VEC [NV] = '{
    {1'b0, 12'h024, 32'hABCD1234, 4'd9},  // R9
    {1'b1, 12'h024, 32'h00001234, 4'd9},
    {1'b0, 12'h028, 32'h000000FF, 4'd9},
    {1'b1, 12'h028, 32'h0000003F, 4'd9},
    {1'b0, 12'h02C, 32'h00000070, 4'd1},
    {1'b1, 12'h02C, 32'h00000070, 4'd1},
    {1'b0, 12'h038, 32'h000007FF, 4'd2},  // R2
    {1'b1, 12'h03C, 32'h00000000, 4'd2},
    {1'b0, 12'h000, 32'h00000041, 4'd6},  // R6
    {1'b1, 12'h03C, 32'h00000020, 4'd6},
    {1'b1, 12'h040, 32'h00000020, 4'd2},
    {1'b0, 12'h038, 32'h00000010, 4'd2},
    {1'b1, 12'h040, 32'h00000000, 4'd2},
    {1'b0, 12'h044, 32'h00000020, 4'd3},  // R3
    {1'b1, 12'h03C, 32'h00000000, 4'd3},
    {1'b1, 12'h044, 32'h00000000, 4'd3},
    {1'b0, 12'h03C, 32'h000007FF, 4'd4},  // R4
    {1'b0, 12'h040, 32'h000007FF, 4'd4},
    {1'b0, 12'h018, 32'hFFFFFFFF, 4'd4},
    {1'b1, 12'h03C, 32'h00000000, 4'd4},
    {1'b1, 12'h038, 32'h00000010, 4'd4},
    {1'b1, 12'h018, 32'h000000A5, 4'd4},
    {1'b1, 12'hFE0, 32'h00000011, 4'd8},  // R8
    {1'b1, 12'hFE4, 32'h00000010, 4'd8},
    {1'b1, 12'hFEC, 32'h00000000, 4'd8},
    {1'b1, 12'hFF4, 32'h000000F0, 4'd8},
    {1'b1, 12'hFFC, 32'h000000B1, 4'd8},
    {1'b1, 12'h100, 32'h00000000, 4'd8}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset values
    rd(12'h034, d); check("R1 fifo level", d, 32'h12);
    rd(12'h038, d); check("R1 mask", d, 0);
    rd(12'h024, d); check("R1 int divisor", d, 0);
    check("R1 irq lines", {26'd0, irq_out}, 0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][48]) begin
        rd(VEC[i][47:36], d);
        check($sformatf("R%0d vector %0d", VEC[i][3:0], i), d, VEC[i][35:4]);
      end else begin
        wr(VEC[i][47:36], VEC[i][35:4]);
      end
    end

    // R11 read data holds between reads
    repeat (2) @(negedge clk);
    check("R11 rdata hold", bus_rdata, 0);

    // R6 transmit strobe
    @(negedge clk); bus_wr = 1'b1; bus_addr = 12'h000; bus_wdata = 32'h1C7;
    @(negedge clk); bus_wr = 1'b0;
    check("R6 tx strobe", {31'd0, tx_strobe}, 1);
    check("R6 tx byte", {24'd0, tx_byte}, 32'hC7);
    @(negedge clk);
    check("R6 strobe one cycle", {31'd0, tx_strobe}, 0);
    wr(12'h044, 32'h7FF);

    // R10 data read
    @(negedge clk); bus_rd = 1'b1; bus_addr = 12'h000;
    @(negedge clk); bus_rd = 1'b0;
    check("R10 rx data", bus_rdata, 32'h5A3);
    check("R10 rx pop", {31'd0, rx_pop}, 1);
    @(negedge clk);
    check("R10 pop one cycle", {31'd0, rx_pop}, 0);

    // R5 receive event: line lags status by one cycle
    wr(12'h038, 32'h7FF);
    @(negedge clk); evt_set = 11'h010;
    @(negedge clk); evt_set = '0;
    check("R5 line before edge", {26'd0, irq_out}, 0);
    @(negedge clk);
    check("R5 rx group", {26'd0, irq_out}, 32'h03);
    wr(12'h044, 32'h010);
    @(negedge clk);
    check("R5 cleared", {26'd0, irq_out}, 0);

    // R5 / R7 each group line
    @(negedge clk); evt_set = 11'h002;
    @(negedge clk); evt_set = '0;
    @(negedge clk); check("R5 modem group", {26'd0, irq_out}, 32'h11);
    @(negedge clk); evt_set = 11'h100;
    @(negedge clk); evt_set = '0;
    @(negedge clk); check("R5 error group", {26'd0, irq_out}, 32'h31);
    rd(12'h03C, d); check("R7 raw bits", d, 32'h102);
    wr(12'h044, 32'h7FF);

    // R7 set wins over simultaneous clear
    @(negedge clk);
    evt_set = 11'h040; bus_wr = 1'b1; bus_addr = 12'h044; bus_wdata = 32'h040;
    @(negedge clk); evt_set = '0; bus_wr = 1'b0;
    rd(12'h03C, d); check("R7 set beats clear", d, 32'h040);
    @(negedge clk); check("R5 timeout group", {26'd0, irq_out}, 32'h09);

    // R2 mask gating lines
    wr(12'h038, 32'h000);
    @(negedge clk); check("R2 masked off lines", {26'd0, irq_out}, 0);
    rd(12'h040, d); check("R2 masked zero", d, 0);

    // R1 reset mid-run
    wr(12'h034, 32'h3);
    wr(12'h038, 32'h7FF);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    rd(12'h034, d); check("R1 fifo level after reset", d, 32'h12);
    rd(12'h03C, d); check("R1 raw after reset", d, 0);
    rd(12'h028, d); check("R1 frac after reset", d, 0);
    check("R1 lines after reset", {26'd0, irq_out}, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule